// File: doc/BRIEF.md
# Distributed-Parity Small-Write Sequencer

This block turns one logical block write into the read-modify-write that a five-column striped array with rotating parity needs. A host presents a logical block address and a block of new data. The block maps the address to a stripe, a data column and that stripe's parity column. It then drives a single disk-operation port through four steps: it reads the old data, reads the old parity, writes the new data and writes the recomputed parity.

The new parity is built in one accumulator register. The accumulator is loaded with the new data when the request is taken. Each of the two reads is folded into it with XOR as its acknowledge arrives. When both reads have completed, the accumulator holds old data ^ new data ^ old parity, ready for the final write.

The controller is a five-state machine. IDLE goes to RD_DATA when a request is taken. RD_DATA goes to RD_PAR, RD_PAR goes to WR_DATA, WR_DATA goes to WR_PAR and WR_PAR goes back to IDLE, each move happening on the disk acknowledge. When WR_PAR is acknowledged, a one-cycle completion pulse is also scheduled.

Top module: `stripe_rmw_engine`

## Requirements
- R1: `busy` is high from the cycle after a request is taken (`wr_valid` while not busy) until the clock edge that accepts the acknowledge of the parity write. `wr_valid` raised while `busy` is high is ignored: it causes no extra disk operation and does not change the operation in progress.
- R2: Each logical write produces exactly four disk operations, in this order: read of the data column, read of the parity column, write of the data column, write of the parity column. A read has `dsk_wr`=0 and a write has `dsk_wr`=1.
- R3: The data sent with the parity write equals old data XOR new data XOR old parity, where the old values are the `dsk_rdata` words returned with the two read acknowledges.
- R4: The stripe number is the address divided by 4. The parity column is 4 − (stripe mod 5), so stripes 0 to 4 place parity on columns 4, 3, 2, 1 and 0, and the pattern repeats.
- R5: The data column is the address mod 4, plus one when that value is at or above the parity column. Addresses therefore fill the non-parity columns in ascending order (stripe 1: columns 0, 1, 2, 4). `dsk_stripe` carries the stripe number on every operation.
- R6: An operation is held, with `dsk_req`, `dsk_col`, `dsk_wr`, `dsk_stripe` and `dsk_wdata` stable, until `dsk_ack` is seen at a clock edge. The next operation starts only after that edge.
- R7: `done` is high for exactly one cycle, the cycle after the parity-write acknowledge. During that cycle `done_stripe` and `done_pcol` show the stripe and parity column of the write that completed.
- R8: After reset, `busy`, `dsk_req` and `done` are low.
- R9: The data write carries the host's new data block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Logical write request |
| wr_lba | input | LBA_W | Logical block address |
| wr_data | input | BLK_W | New block data |
| busy | output | 1 | Write sequence in progress |
| dsk_req | output | 1 | Disk operation request |
| dsk_wr | output | 1 | 1 = write, 0 = read |
| dsk_col | output | COL_W | Disk column index |
| dsk_stripe | output | LBA_W | Stripe number (block within the disk) |
| dsk_wdata | output | BLK_W | Block data for writes |
| dsk_ack | input | 1 | Operation acknowledge |
| dsk_rdata | input | BLK_W | Read data, valid with dsk_ack on reads |
| done | output | 1 | One-cycle completion pulse |
| done_stripe | output | LBA_W | Stripe of the completed write |
| done_pcol | output | COL_W | Parity column of the completed write |

## Verification
The addresses span five consecutive stripes and every slot within each stripe. This covers every parity rotation, and it includes the slots that sit before, at and after the parity column, so it exposes any column skip that is off by one. The data patterns are all zeros, all ones, alternating bits and walking values, and some addresses are written twice in a row. With these patterns, a parity that ignored the old data or the old parity would break the per-stripe XOR invariant that the bench checks after every write. Acknowledge latencies of zero, one and three cycles separate correct hold-until-acknowledge behaviour from a sequencer that advances on a fixed count. Requests raised while busy show whether a new request can corrupt the operation in flight.

// File: rtl/stripe_rmw_pkg.sv
package stripe_rmw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DATA,
        ST_RD_PAR,
        ST_WR_DATA,
        ST_WR_PAR
    } rmw_state_e;

endpackage

// File: rtl/stripe_lba_map.sv
module stripe_lba_map #(
    parameter int LBA_W = 16,
    parameter int NCOL  = 5,
    parameter int COL_W = 3
) (
    input  logic [LBA_W-1:0] lba,
    output logic [LBA_W-1:0] stripe,
    output logic [COL_W-1:0] dcol,
    output logic [COL_W-1:0] pcol
);
    localparam int DCOL = NCOL - 1;

    logic [COL_W-1:0] slot;

    always_comb begin
        stripe = lba / LBA_W'(DCOL);
        slot   = COL_W'(lba % LBA_W'(DCOL));
        // parity walks downward one column per stripe
        pcol   = COL_W'(DCOL) - COL_W'(stripe % LBA_W'(NCOL));
        // data slots skip over the parity column
        dcol   = (slot >= pcol) ? slot + COL_W'(1) : slot;
    end
endmodule

// File: rtl/stripe_par_acc.sv
module stripe_par_acc #(
    parameter int BLK_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [BLK_W-1:0] load_val,
    input  logic             fold,
    input  logic [BLK_W-1:0] fold_val,
    output logic [BLK_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (load)
            acc <= load_val;
        else if (fold)
            acc <= acc ^ fold_val;
    end
endmodule

// File: rtl/stripe_rmw_seq.sv
module stripe_rmw_seq
    import stripe_rmw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic dsk_ack,
    output logic busy,
    output logic accept,
    output logic dsk_req,
    output logic dsk_wr,
    output logic sel_par,
    output logic fold,
    output logic done
);
    rmw_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_WR_PAR) && dsk_ack;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_req) nxt = ST_RD_DATA;
            ST_RD_DATA: if (dsk_ack)   nxt = ST_RD_PAR;
            ST_RD_PAR:  if (dsk_ack)   nxt = ST_WR_DATA;
            ST_WR_DATA: if (dsk_ack)   nxt = ST_WR_PAR;
            ST_WR_PAR:  if (dsk_ack)   nxt = ST_IDLE;
            default:                   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy    = 1'b1;
        accept  = 1'b0;
        dsk_req = 1'b1;
        dsk_wr  = 1'b0;
        sel_par = 1'b0;
        fold    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy    = 1'b0;
                dsk_req = 1'b0;
                accept  = start_req;
            end
            ST_RD_DATA: fold = dsk_ack;
            ST_RD_PAR: begin
                sel_par = 1'b1;
                fold    = dsk_ack;
            end
            ST_WR_DATA: dsk_wr = 1'b1;
            ST_WR_PAR: begin
                dsk_wr  = 1'b1;
                sel_par = 1'b1;
            end
            default: begin
                busy    = 1'b0;
                dsk_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/stripe_rmw_engine.sv
module stripe_rmw_engine #(
    parameter int BLK_W = 32,
    parameter int LBA_W = 16,
    parameter int NCOL  = 5,
    localparam int COL_W = $clog2(NCOL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [LBA_W-1:0] wr_lba,
    input  logic [BLK_W-1:0] wr_data,
    output logic             busy,
    output logic             dsk_req,
    output logic             dsk_wr,
    output logic [COL_W-1:0] dsk_col,
    output logic [LBA_W-1:0] dsk_stripe,
    output logic [BLK_W-1:0] dsk_wdata,
    input  logic             dsk_ack,
    input  logic [BLK_W-1:0] dsk_rdata,
    output logic             done,
    output logic [LBA_W-1:0] done_stripe,
    output logic [COL_W-1:0] done_pcol
);
    logic [LBA_W-1:0] map_stripe;
    logic [COL_W-1:0] map_dcol, map_pcol;
    logic [LBA_W-1:0] cur_stripe;
    logic [COL_W-1:0] cur_dcol, cur_pcol;
    logic [BLK_W-1:0] cur_data, par_acc;
    logic             accept, sel_par, fold;

    stripe_lba_map #(.LBA_W(LBA_W), .NCOL(NCOL), .COL_W(COL_W)) u_map (
        .lba    (wr_lba),
        .stripe (map_stripe),
        .dcol   (map_dcol),
        .pcol   (map_pcol)
    );

    stripe_rmw_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (wr_valid),
        .dsk_ack   (dsk_ack),
        .busy      (busy),
        .accept    (accept),
        .dsk_req   (dsk_req),
        .dsk_wr    (dsk_wr),
        .sel_par   (sel_par),
        .fold      (fold),
        .done      (done)
    );

    stripe_par_acc #(.BLK_W(BLK_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (wr_data),
        .fold     (fold),
        .fold_val (dsk_rdata),
        .acc      (par_acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_stripe <= '0;
            cur_dcol   <= '0;
            cur_pcol   <= '0;
            cur_data   <= '0;
        end else if (accept) begin
            cur_stripe <= map_stripe;
            cur_dcol   <= map_dcol;
            cur_pcol   <= map_pcol;
            cur_data   <= wr_data;
        end
    end

    always_comb begin
        dsk_col     = sel_par ? cur_pcol : cur_dcol;
        dsk_wdata   = sel_par ? par_acc : cur_data;
        dsk_stripe  = cur_stripe;
        done_stripe = cur_stripe;
        done_pcol   = cur_pcol;
    end
endmodule

// File: rtl/stripe_rmw_chk.sv
module stripe_rmw_chk #(
    parameter int BLK_W = 32,
    parameter int LBA_W = 16,
    parameter int NCOL  = 5,
    parameter int COL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             dsk_req,
    input logic             dsk_wr,
    input logic [COL_W-1:0] dsk_col,
    input logic [LBA_W-1:0] dsk_stripe,
    input logic [BLK_W-1:0] dsk_wdata,
    input logic             dsk_ack,
    input logic             done,
    input logic [LBA_W-1:0] done_stripe,
    input logic [COL_W-1:0] done_pcol
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dsk_req); // R1

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !(dsk_ack && dsk_wr)) |=> busy); // R1

    AST_FIRST_OP_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (dsk_req && !dsk_wr)); // R2

    AST_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (dsk_req && !dsk_ack) |=> (dsk_req && $stable(dsk_col) && $stable(dsk_wr)
                                   && $stable(dsk_stripe) && $stable(dsk_wdata))); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_DONE_AFTER_PAR: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(dsk_req && dsk_ack && dsk_wr) && !busy
                  && ($past(dsk_col) == done_pcol))); // R7

    AST_PAR_ROTATION: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(done_pcol) == (NCOL - 1) - int'(done_stripe % LBA_W'(NCOL)))); // R4
endmodule

bind stripe_rmw_engine stripe_rmw_chk #(
    .BLK_W(BLK_W), .LBA_W(LBA_W), .NCOL(NCOL), .COL_W(COL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .dsk_req     (dsk_req),
    .dsk_wr      (dsk_wr),
    .dsk_col     (dsk_col),
    .dsk_stripe  (dsk_stripe),
    .dsk_wdata   (dsk_wdata),
    .dsk_ack     (dsk_ack),
    .done        (done),
    .done_stripe (done_stripe),
    .done_pcol   (done_pcol)
);

// File: tb/tb_stripe_rmw_engine.sv
`timescale 1ns/1ps
module tb_stripe_rmw_engine;
    localparam int BW = 32;
    localparam int AW = 16;
    localparam int CW = 3;
    localparam int NS = 12;

    typedef struct {
        int          col;
        bit          wr;
        int          stripe;
        logic [31:0] d;
    } op_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_lba = '0;
    logic [BW-1:0] wr_data = '0;
    logic          busy, dsk_req, dsk_wr, done;
    logic [CW-1:0] dsk_col, done_pcol;
    logic [AW-1:0] dsk_stripe, done_stripe;
    logic [BW-1:0] dsk_wdata;
    logic          dsk_ack = 1'b0;
    logic [BW-1:0] dsk_rdata = '0;

    always #2.5 clk = ~clk;

    stripe_rmw_engine #(.BLK_W(BW), .LBA_W(AW), .NCOL(5)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_lba(wr_lba), .wr_data(wr_data),
        .busy(busy), .dsk_req(dsk_req), .dsk_wr(dsk_wr), .dsk_col(dsk_col),
        .dsk_stripe(dsk_stripe), .dsk_wdata(dsk_wdata), .dsk_ack(dsk_ack),
        .dsk_rdata(dsk_rdata), .done(done), .done_stripe(done_stripe), .done_pcol(done_pcol)
    );

    logic [31:0] mem [NS][5];
    op_t  expq[$];
    int   n_chk = 0, n_fail = 0, cyc = 0;
    int   issued = 0, seen = 0, lat = 0, lat_cfg = 0;
    bit   exp_busy = 0, exp_done = 0, exp_done_next = 0;
    int   exp_dstripe = 0, exp_dpcol = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // disk model and per-clock comparison
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (seen != issued) begin
                seen = issued;
                exp_busy = 1;
            end
            if (exp_done_next) begin
                exp_done = 1;
                exp_done_next = 0;
                exp_busy = 0;
            end else begin
                exp_done = 0;
            end
            chk(busy == exp_busy, "R1", "busy", busy, exp_busy);
            chk(done == exp_done, "R7", "done", done, exp_done);
            if (exp_done) begin
                chk(int'(done_stripe) == exp_dstripe, "R7", "done_stripe", done_stripe, exp_dstripe);
                chk(int'(done_pcol) == exp_dpcol, "R7", "done_pcol", done_pcol, exp_dpcol);
            end
            if (dsk_ack) begin
                dsk_ack = 0;
                lat = lat_cfg;
            end else if (dsk_req) begin
                if (lat > 0) begin
                    lat--;
                end else begin
                    dsk_ack = 1;
                    if (expq.size() == 0) begin
                        chk(0, "R1", "unexpected disk op", dsk_col, 0);
                    end else begin
                        op_t e;
                        e = expq.pop_front();
                        chk(int'(dsk_wr) == int'(e.wr), "R2", "op direction", dsk_wr, e.wr);
                        chk(int'(dsk_col) == e.col, e.col == exp_dpcol ? "R4" : "R5",
                            "column", dsk_col, e.col);
                        chk(int'(dsk_stripe) == e.stripe, "R5", "stripe", dsk_stripe, e.stripe);
                        if (e.wr) begin
                            chk(dsk_wdata == e.d, expq.size() == 0 ? "R3" : "R9",
                                "write data", dsk_wdata, e.d);
                            if (int'(dsk_stripe) < NS && int'(dsk_col) < 5)
                                mem[dsk_stripe][dsk_col] = dsk_wdata;
                        end else begin
                            dsk_rdata = (int'(dsk_stripe) < NS && int'(dsk_col) < 5)
                                        ? mem[dsk_stripe][dsk_col] : 32'hDEAD_BEEF;
                        end
                        if (expq.size() == 0) exp_done_next = 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
            $finish;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy || exp_done_next || expq.size() != 0) @(negedge clk);
    endtask

    task automatic check_parity();
        for (int s = 0; s < NS; s++) begin
            logic [31:0] x;
            x = 0;
            for (int c = 0; c < 5; c++) x ^= mem[s][c];
            chk(x == 0, "R3", $sformatf("stripe %0d parity invariant", s), x, 0);
        end
    endtask

    task automatic do_write(input int lba, input logic [31:0] d, input bit poke);
        int s, slot, p, dc;
        logic [31:0] np;
        wait_idle();
        s    = lba / 4;
        slot = lba % 4;
        p    = 4 - (s % 5);
        dc   = (slot < p) ? slot : slot + 1;
        np   = mem[s][dc] ^ d ^ mem[s][p];
        expq.push_back('{dc, 1'b0, s, 32'h0});
        expq.push_back('{p,  1'b0, s, 32'h0});
        expq.push_back('{dc, 1'b1, s, d});
        expq.push_back('{p,  1'b1, s, np});
        exp_dstripe = s;
        exp_dpcol   = p;
        wr_valid = 1'b1;
        wr_lba   = AW'(lba);
        wr_data  = d;
        issued <= issued + 1;
        @(negedge clk);
        if (poke) begin
            // R1: requests while busy must be ignored
            wr_lba  = AW'((lba + 7) % (NS * 4));
            wr_data = ~d;
            repeat (3) @(negedge clk);
        end
        wr_valid = 1'b0;
        wait_idle();
        check_parity();
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin
            logic [31:0] x;
            x = 0;
            for (int c = 0; c < 4; c++) begin
                mem[s][c] = 32'h1357_9BDF * (s * 5 + c + 1);
                x ^= mem[s][c];
            end
            mem[s][4] = 32'h0;
            mem[s][4 - (s % 5)] = x;
            if (4 - (s % 5) != 4) mem[s][4] = 32'h1357_9BDF * (s * 5 + 4 - (s % 5) + 1);
        end
        // rebuild so each stripe holds four data words plus a consistent parity
        for (int s = 0; s < NS; s++) begin
            logic [31:0] x;
            x = 0;
            for (int c = 0; c < 5; c++) if (c != 4 - (s % 5)) x ^= mem[s][c];
            mem[s][4 - (s % 5)] = x;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0, "R8", "busy after reset", busy, 0);
        chk(dsk_req == 0, "R8", "dsk_req after reset", dsk_req, 0);
        chk(done == 0, "R8", "done after reset", done, 0);

        // R4 R5: every slot of five stripes, zero-latency disk
        lat_cfg = 0;
        for (int a = 0; a < 20; a++) do_write(a, 32'hA5A5_0000 + 32'(a), 1'b0);
        // all-zero and all-one data, one-cycle latency
        lat_cfg = 1;
        do_write(21, 32'h0, 1'b0);
        do_write(21, 32'hFFFF_FFFF, 1'b0);
        do_write(33, 32'h5555_5555, 1'b0);
        do_write(33, 32'hAAAA_AAAA, 1'b0);
        // R6: longer latency, walking ones
        lat_cfg = 3;
        for (int b = 0; b < 8; b++) do_write(24 + b, 32'h1 << (b * 4), 1'b0);
        // R1: pokes while busy
        for (int k = 0; k < 4; k++) do_write(40 + k, 32'hC0DE_0000 ^ 32'(k * 17), 1'b1);
        lat_cfg = 0;
        do_write(47, 32'h0F0F_F0F0, 1'b1);
        wait_idle();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule